// File: doc/BRIEF.md
# Width-Slicing Target Read Sequencer

This block sits between the target side of a PCI bus core and user logic that has only a narrow port. It carries a 64-bit dual-address burst read across that port one slice at a time. A small state counter names the current slice. The counter picks which part of the 64-bit bus address goes out to user logic during the command/address phase. It also picks which part of the 64-bit read word is taken in from user logic during the data phase. A mode input chooses between two 32-bit slices and four 16-bit slices.

The handshakes are all active low: a request, an address enable, a read-data enable, a last-read-data strobe and a last-command/address strobe. An address transfer sends one address slice, registered, and moves the counter on. A data transfer captures one data slice into a 64-bit assembly register and moves the counter on. Either phase ends when the counter wraps after its final slice, or earlier when that phase's last strobe is seen. Completing a read raises a one-cycle pulse.

Top module: `tgt_rd_seq`

## Requirements
- R1: A synchronous active-high reset clears the state counter, the address output, the assembled data output and the complete pulse to zero.
- R2: While `req_n` is high the block is idle. The counter is 0 one cycle later, and the address and data outputs keep their values.
- R3: An address transfer happens in a cycle with `req_n` and `aen_n` both low. It registers the current address slice onto `addr_o` and advances the counter. In any other cycle `addr_o` does not change.
- R4: A data transfer happens in a cycle with `req_n` low, `aen_n` high and `rden_n` low. It captures the current data slice and advances the counter. When `aen_n` and `rden_n` are both low, the address transfer takes place and `rdata_o` does not change.
- R5: `mode_i` = 0 selects 32-bit mode. State 0 carries address bits 31:0 and data bits 31:0. State 1 carries address bits 63:32 and data bits 63:32. `addr_o[35:32]` is driven 0, data is taken from `rd_i[31:0]`, and state 1 always goes next to 0.
- R6: `mode_i` = 1 selects 16-bit mode. States 0, 1, 2 and 3 carry address and data bits 15:0, 31:16, 47:32 and 63:48, in that order. `addr_o[35:16]` is driven 0, data is taken from `rd_i[15:0]`, and state 3 always goes next to 0.
- R7: A data transfer with `rlast_n` low captures its slice and returns the counter to 0.
- R8: An address transfer with `clast_n` low sends its slice and returns the counter to 0.
- R9: `done_o` is high for exactly the one cycle after a data transfer that captures the final slice or that has `rlast_n` low. Address transfers never raise it.
- R10: The mode is sampled only while the counter is 0. A change of `mode_i` in the middle of a burst has no effect until the counter is back at 0.
- R11: A data transfer in state 0 clears every part of `rdata_o` other than the slice it writes.
- R12: A cycle with `req_n` low and both `aen_n` and `rden_n` high leaves the counter and all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Active-low request; high means idle |
| aen_n | input | 1 | Active-low command/address enable |
| rden_n | input | 1 | Active-low read-data enable |
| rlast_n | input | 1 | Active-low last read-data strobe |
| clast_n | input | 1 | Active-low last command/address strobe |
| mode_i | input | 1 | 0: two 32-bit slices, 1: four 16-bit slices |
| addr_i | input | 64 | Full bus address from the target core |
| rd_i | input | 32 | Read-data slice from user logic |
| addr_o | output | 36 | Registered address slice to user logic |
| rdata_o | output | 64 | Assembled 64-bit read data |
| state_o | output | 2 | Current slice counter |
| done_o | output | 1 | One-cycle read-complete pulse |

## Verification
The bench builds the block with its default parameters: a 64-bit address, 32-bit wide slices with a 4-bit side field, and 16-bit narrow slices with a 2-bit side field. These values make both slice patterns reachable in one build: the two-state wrap of 32-bit mode and the four-state wrap of 16-bit mode. Runs that switch between the modes in the same build can then check the mid-burst mode change and the lane clearing that a new capture at state 0 performs after a wider earlier burst.

// File: rtl/tgt_rd_seq_pkg.sv
package tgt_rd_seq_pkg;

  typedef enum logic {
    SLICE_WIDE   = 1'b0,
    SLICE_NARROW = 1'b1
  } slice_mode_e;

endpackage

// File: rtl/tgt_rd_ctrl.sv
module tgt_rd_ctrl
  import tgt_rd_seq_pkg::*;
#(
  parameter int WIDE_SLICES   = 2,
  parameter int NARROW_SLICES = 4,
  parameter int CNT_W         = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_n,
  input  logic             aen_n,
  input  logic             rden_n,
  input  logic             rlast_n,
  input  logic             clast_n,
  input  logic             mode_i,
  output logic [CNT_W-1:0] idx_o,
  output slice_mode_e      mode_eff_o,
  output logic             addr_xfer_o,
  output logic             data_xfer_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WIDE_SLICES - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_SLICES - 1);

  logic [CNT_W-1:0] cnt_q;
  slice_mode_e      mode_q;
  slice_mode_e      mode_eff;
  logic             done_q;
  logic             at_zero;
  logic             at_last;
  logic             addr_xfer;
  logic             data_xfer;
  logic             addr_end;
  logic             data_end;

  assign at_zero   = (cnt_q == '0);
  assign mode_eff  = at_zero ? slice_mode_e'(mode_i) : mode_q;
  assign at_last   = (mode_eff == SLICE_NARROW) ? (cnt_q == LAST_NARROW)
                                                : (cnt_q == LAST_WIDE);
  assign addr_xfer = !req_n && !aen_n;
  assign data_xfer = !req_n && aen_n && !rden_n;
  assign addr_end  = addr_xfer && (at_last || !clast_n);
  assign data_end  = data_xfer && (at_last || !rlast_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= SLICE_WIDE;
      done_q <= 1'b0;
    end else begin
      done_q <= data_end;
      if (at_zero) begin
        mode_q <= slice_mode_e'(mode_i);
      end
      if (req_n) begin
        cnt_q <= '0;
      end else if (addr_end || data_end) begin
        cnt_q <= '0;
      end else if (addr_xfer || data_xfer) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign idx_o       = cnt_q;
  assign mode_eff_o  = mode_eff;
  assign addr_xfer_o = addr_xfer;
  assign data_xfer_o = data_xfer;
  assign done_o      = done_q;

endmodule

// File: rtl/tgt_addr_slicer.sv
module tgt_addr_slicer
  import tgt_rd_seq_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int WIDE_W        = 32,
  parameter int NARROW_W      = 16,
  parameter int OUT_W         = 36,
  parameter int WIDE_SLICES   = 2,
  parameter int NARROW_SLICES = 4,
  parameter int CNT_W         = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  slice_mode_e       mode_i,
  input  logic              xfer_i,
  output logic [OUT_W-1:0]  addr_o
);

  localparam int WIX_W = (WIDE_SLICES > 1) ? $clog2(WIDE_SLICES) : 1;

  logic [WIDE_W-1:0]   wide_sl   [WIDE_SLICES];
  logic [NARROW_W-1:0] narrow_sl [NARROW_SLICES];
  logic [OUT_W-1:0]    addr_q;

  for (genvar w = 0; w < WIDE_SLICES; w++) begin : g_wide
    assign wide_sl[w] = addr_i[w*WIDE_W +: WIDE_W];
  end

  for (genvar n = 0; n < NARROW_SLICES; n++) begin : g_narrow
    assign narrow_sl[n] = addr_i[n*NARROW_W +: NARROW_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (xfer_i) begin
      if (mode_i == SLICE_NARROW) begin
        addr_q <= OUT_W'(narrow_sl[idx_i]);
      end else begin
        addr_q <= OUT_W'(wide_sl[idx_i[WIX_W-1:0]]);
      end
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/tgt_rdata_asm.sv
module tgt_rdata_asm
  import tgt_rd_seq_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int WIDE_W        = 32,
  parameter int NARROW_W      = 16,
  parameter int NARROW_SLICES = 4,
  parameter int CNT_W         = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDE_W-1:0] rd_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  slice_mode_e       mode_i,
  input  logic              xfer_i,
  output logic [ADDR_W-1:0] rdata_o
);

  localparam int LANES_PER_WIDE = WIDE_W / NARROW_W;

  for (genvar j = 0; j < NARROW_SLICES; j++) begin : g_lane
    localparam int WIDE_IX = j / LANES_PER_WIDE;
    localparam int SUB_IX  = j % LANES_PER_WIDE;

    logic [NARROW_W-1:0] lane_q;
    logic                wr_narrow;
    logic                wr_wide;
    logic                clr;

    assign wr_narrow = xfer_i && (mode_i == SLICE_NARROW) && (idx_i == CNT_W'(j));
    assign wr_wide   = xfer_i && (mode_i == SLICE_WIDE) && (idx_i == CNT_W'(WIDE_IX));
    assign clr       = xfer_i && (idx_i == '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (wr_narrow) begin
        lane_q <= rd_i[NARROW_W-1:0];
      end else if (wr_wide) begin
        lane_q <= rd_i[SUB_IX*NARROW_W +: NARROW_W];
      end else if (clr) begin
        lane_q <= '0;
      end
    end

    assign rdata_o[j*NARROW_W +: NARROW_W] = lane_q;
  end

endmodule

// File: rtl/tgt_rd_seq.sv
module tgt_rd_seq
  import tgt_rd_seq_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int WIDE_W        = 32,
  parameter int NARROW_W      = 16,
  parameter int WIDE_SIDE_W   = 4,
  parameter int NARROW_SIDE_W = 2,
  parameter int OUT_W         = WIDE_W + WIDE_SIDE_W,
  parameter int CNT_W         = $clog2(ADDR_W / NARROW_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_n,
  input  logic              aen_n,
  input  logic              rden_n,
  input  logic              rlast_n,
  input  logic              clast_n,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDE_W-1:0] rd_i,
  output logic [OUT_W-1:0]  addr_o,
  output logic [ADDR_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  state_o,
  output logic              done_o
);

  localparam int WIDE_SLICES   = ADDR_W / WIDE_W;
  localparam int NARROW_SLICES = ADDR_W / NARROW_W;

  logic [CNT_W-1:0] idx;
  slice_mode_e      mode_eff;
  logic             addr_xfer;
  logic             data_xfer;

  tgt_rd_ctrl #(
    .WIDE_SLICES  (WIDE_SLICES),
    .NARROW_SLICES(NARROW_SLICES),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_n      (req_n),
    .aen_n      (aen_n),
    .rden_n     (rden_n),
    .rlast_n    (rlast_n),
    .clast_n    (clast_n),
    .mode_i     (mode_i),
    .idx_o      (idx),
    .mode_eff_o (mode_eff),
    .addr_xfer_o(addr_xfer),
    .data_xfer_o(data_xfer),
    .done_o     (done_o)
  );

  tgt_addr_slicer #(
    .ADDR_W       (ADDR_W),
    .WIDE_W       (WIDE_W),
    .NARROW_W     (NARROW_W),
    .OUT_W        (OUT_W),
    .WIDE_SLICES  (WIDE_SLICES),
    .NARROW_SLICES(NARROW_SLICES),
    .CNT_W        (CNT_W)
  ) u_addr (
    .clk   (clk),
    .rst   (rst),
    .addr_i(addr_i),
    .idx_i (idx),
    .mode_i(mode_eff),
    .xfer_i(addr_xfer),
    .addr_o(addr_o)
  );

  tgt_rdata_asm #(
    .ADDR_W       (ADDR_W),
    .WIDE_W       (WIDE_W),
    .NARROW_W     (NARROW_W),
    .NARROW_SLICES(NARROW_SLICES),
    .CNT_W        (CNT_W)
  ) u_rdata (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (rd_i),
    .idx_i  (idx),
    .mode_i (mode_eff),
    .xfer_i (data_xfer),
    .rdata_o(rdata_o)
  );

  assign state_o = idx;

endmodule

// File: rtl/tgt_rd_seq_chk.sv
module tgt_rd_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int WIDE_W = 32,
  parameter int OUT_W  = 36,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_n,
  input logic              aen_n,
  input logic              rden_n,
  input logic              mode_i,
  input logic [OUT_W-1:0]  addr_o,
  input logic [ADDR_W-1:0] rdata_o,
  input logic [CNT_W-1:0]  state_o,
  input logic              done_o
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (state_o == '0 && done_o == 1'b0 && addr_o == '0 && rdata_o == '0));

  p_idle_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
    req_n |=> (state_o == '0));

  p_addr_only_on_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    (req_n || aen_n) |=> $stable(addr_o));

  p_addr_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (!req_n && !aen_n) |=> $stable(rdata_o));

  p_wide_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == '0 && !mode_i) |=> (state_o <= CNT_W'(1)));

  p_done_after_data_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(!req_n && aen_n && !rden_n));

  p_hold_when_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!req_n && aen_n && rden_n) |=> ($stable(state_o) && $stable(addr_o) && $stable(rdata_o)));

endmodule

bind tgt_rd_seq tgt_rd_seq_chk #(
  .ADDR_W(ADDR_W),
  .WIDE_W(WIDE_W),
  .OUT_W (OUT_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .req_n  (req_n),
  .aen_n  (aen_n),
  .rden_n (rden_n),
  .mode_i (mode_i),
  .addr_o (addr_o),
  .rdata_o(rdata_o),
  .state_o(state_o),
  .done_o (done_o)
);

// File: tb/tb_tgt_rd_seq.sv
module tb_tgt_rd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_n, aen_n, rden_n, rlast_n, clast_n, mode_i;
  logic [63:0] addr_i;
  logic [31:0] rd_i;
  logic [35:0] addr_o;
  logic [63:0] rdata_o;
  logic [1:0]  state_o;
  logic        done_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgt_rd_seq dut (
    .clk(clk), .rst(rst), .req_n(req_n), .aen_n(aen_n), .rden_n(rden_n),
    .rlast_n(rlast_n), .clast_n(clast_n), .mode_i(mode_i), .addr_i(addr_i),
    .rd_i(rd_i), .addr_o(addr_o), .rdata_o(rdata_o), .state_o(state_o),
    .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle of handshakes, then sample just after the edge
  task automatic step(input logic rq, input logic ae, input logic rde,
                      input logic rl, input logic cl);
    req_n = rq; aen_n = ae; rden_n = rde; rlast_n = rl; clast_n = cl;
    @(posedge clk);
    #1;
  endtask

  task automatic addr_x(input logic cl);  step(1'b0, 1'b0, 1'b1, 1'b1, cl); endtask
  task automatic data_x(input logic rl);  step(1'b0, 1'b1, 1'b0, rl, 1'b1); endtask
  task automatic idle();                  step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1); endtask

  task automatic t_reset();
    rst = 1'b1;
    idle();
    idle();
    rst = 1'b0;
    chk("R1 state", 64'(state_o), 64'd0);
    chk("R1 addr", 64'(addr_o), 64'd0);
    chk("R1 rdata", rdata_o, 64'd0);
    chk("R1 done", 64'(done_o), 64'd0);
  endtask

  task automatic t_wide_burst();
    mode_i = 1'b0;
    addr_i = 64'h1122_3344_5566_7788;
    addr_x(1'b1);
    chk("R5 addr lo", 64'(addr_o), 64'h0_5566_7788);
    chk("R3 state adv", 64'(state_o), 64'd1);
    addr_x(1'b1);
    chk("R5 addr hi", 64'(addr_o), 64'h0_1122_3344);
    chk("R5 wrap", 64'(state_o), 64'd0);
    rd_i = 32'hAAAA_0001;
    data_x(1'b1);
    chk("R4 rdata lo", rdata_o, 64'h0000_0000_AAAA_0001);
    chk("R9 no done mid", 64'(done_o), 64'd0);
    rd_i = 32'hBBBB_0002;
    data_x(1'b1);
    chk("R5 rdata full", rdata_o, 64'hBBBB_0002_AAAA_0001);
    chk("R5 data wrap", 64'(state_o), 64'd0);
    chk("R9 done final", 64'(done_o), 64'd1);
    idle();
    chk("R9 done one cycle", 64'(done_o), 64'd0);
  endtask

  task automatic t_narrow_burst();
    logic [15:0] exp_a [4];
    logic [15:0] dat [4];
    mode_i = 1'b1;
    addr_i = 64'hFEDC_BA98_7654_3210;
    exp_a[0] = 16'h3210; exp_a[1] = 16'h7654; exp_a[2] = 16'hBA98; exp_a[3] = 16'hFEDC;
    dat[0] = 16'h0A01; dat[1] = 16'h0B02; dat[2] = 16'h0C03; dat[3] = 16'h0D04;
    for (int k = 0; k < 4; k++) begin
      addr_x(1'b1);
      chk("R6 addr slice", 64'(addr_o), 64'(exp_a[k]));
      chk("R6 state seq", 64'(state_o), 64'((k + 1) % 4));
    end
    for (int k = 0; k < 4; k++) begin
      rd_i = {16'hFFFF, dat[k]};
      data_x(1'b1);
      chk("R9 done only last", 64'(done_o), (k == 3) ? 64'd1 : 64'd0);
    end
    chk("R6 rdata full", rdata_o, 64'h0D04_0C03_0B02_0A01);
  endtask

  task automatic t_rlast_and_clear();
    mode_i = 1'b1;
    rd_i = 32'h1234_5555;
    data_x(1'b1);
    chk("R11 lanes cleared", rdata_o, 64'h0000_0000_0000_5555);
    rd_i = 32'h1234_6666;
    data_x(1'b0);
    chk("R7 rlast state", 64'(state_o), 64'd0);
    chk("R7 rlast rdata", rdata_o, 64'h0000_0000_6666_5555);
    chk("R9 done on rlast", 64'(done_o), 64'd1);
  endtask

  task automatic t_clast();
    mode_i = 1'b1;
    addr_i = 64'h0000_0000_0000_ABCD;
    addr_x(1'b0);
    chk("R8 clast state", 64'(state_o), 64'd0);
    chk("R8 clast addr", 64'(addr_o), 64'h0_0000_ABCD);
    chk("R9 no done addr", 64'(done_o), 64'd0);
  endtask

  task automatic t_idle_mid();
    logic [63:0] keep_d;
    mode_i = 1'b1;
    addr_i = 64'h0000_0000_9999_8888;
    addr_x(1'b1);
    keep_d = rdata_o;
    addr_i = 64'hFFFF_FFFF_FFFF_FFFF;
    idle();
    chk("R2 idle state", 64'(state_o), 64'd0);
    chk("R2 idle addr", 64'(addr_o), 64'h0_0000_8888);
    chk("R2 idle rdata", rdata_o, keep_d);
  endtask

  task automatic t_hold_and_priority();
    logic [63:0] keep_d;
    mode_i = 1'b1;
    addr_i = 64'h0000_0000_4444_2222;
    addr_x(1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R12 hold state", 64'(state_o), 64'd1);
    chk("R12 hold addr", 64'(addr_o), 64'h0_0000_2222);
    keep_d = rdata_o;
    rd_i = 32'hDEAD_BEEF;
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 addr wins addr", 64'(addr_o), 64'h0_0000_4444);
    chk("R4 addr wins rdata", rdata_o, keep_d);
    idle();
  endtask

  task automatic t_mode_mid();
    mode_i = 1'b0;
    addr_i = 64'h7777_6666_5555_4444;
    addr_x(1'b1);
    mode_i = 1'b1;
    addr_x(1'b1);
    chk("R10 mode kept addr", 64'(addr_o), 64'h0_7777_6666);
    chk("R10 mode kept wrap", 64'(state_o), 64'd0);
    addr_x(1'b1);
    chk("R10 new mode idle", 64'(addr_o), 64'h0_0000_4444);
    chk("R10 new mode state", 64'(state_o), 64'd1);
    idle();
  endtask

  initial begin
    req_n = 1'b1; aen_n = 1'b1; rden_n = 1'b1; rlast_n = 1'b1; clast_n = 1'b1;
    mode_i = 1'b0; addr_i = '0; rd_i = '0; rst = 1'b1;
    t_reset();
    t_wide_burst();
    t_narrow_burst();
    t_rlast_and_clear();
    t_clast();
    t_idle_mid();
    t_hold_and_priority();
    t_mode_mid();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule